// File: doc/BRIEF.md
# Black-Level Offset Calibration Controller

This block is the digital half of a black-level servo for an image-sensor front end. Once per line the sensor readout passes over shielded (dark) pixels. During that interval the clamp strobe is held low. While the strobe is low, the controller sums the first sixteen 10-bit converter samples it accepts. When the strobe returns high it turns the sum into an average with a 4-bit right shift, and it measures how far that average sits from a programmable black target.

The controller drives two correction codes toward the analog chain. The first is a signed fine code worth exactly one converter LSB per step, limited to ±255. The second is an unsigned 8-bit coarse code whose step is worth several converter LSBs. If the fine code alone would have to leave its range, the coarse code moves by one step on that line. The fine code is then preset to the residue that is left after the coarse step. The coarse step weight comes from the gain code, which is latched at the start of each window. A settled flag reports that the loop has converged. Samples arrive over a valid/ready port. The block never applies back-pressure: ready is held high and a sample transfers on every cycle that valid is high.

Top module: `bl_offset_cal`

## Requirements
- R1: After reset the coarse code is 128, the fine code is 0, settled is 0 and the target register holds 64 (0x40).
- R2: A window opens on the first clock at which `clamp_n` is sampled low. The first 16 samples with `adc_valid` high in that window are summed. Cycles with valid low are skipped, and samples after the sixteenth are ignored. The average is the sum shifted right by 4.
- R3: If a window closes with fewer than 16 accepted samples, the coarse code, fine code and settled flag all keep their values.
- R4: Codes and the flag change only at the clock edge at which `clamp_n` is first sampled high after a full window. They are stable at every other edge.
- R5: The error is e = average − target, and the required fine code is f = fine − e. If −255 ≤ f ≤ 255, the fine code becomes f and the coarse code is unchanged.
- R6: If f > 255, the coarse code rises by 1 and the fine code becomes f − w. If f < −255, the coarse code falls by 1 and the fine code becomes f + w. The resulting fine code is limited to ±255.
- R7: The coarse weight is w = floor(n·(128 + g)/128), where g is the latched gain code. n is 4 for g < 128, 3 for 128 ≤ g < 192, 2 for 192 ≤ g < 256 and 1 for g ≥ 256.
- R8: The coarse code does not step below 0 or above 255. At a limit, the fine code becomes f limited to ±255.
- R9: The fine code, read as 9-bit two's complement, always lies within −255..255.
- R10: After each full window, settled becomes 1 exactly when −1 ≤ e ≤ 1 and the coarse code did not step on that line. Otherwise it becomes 0.
- R11: A clock with `tgt_wr_en` high loads `tgt_wr_data` into the target register. The new target is used at the next comparison.
- R12: The gain code is taken at the window's opening clock. Changes to it during the window have no effect on that line's update.
- R13: `adc_ready` is high at every clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clamp_n | input | 1 | Active-low dark-pixel window strobe |
| adc_valid | input | 1 | Converter sample valid |
| adc_ready | output | 1 | Sample accepted (always high) |
| adc_data | input | 10 | Converter sample code |
| gain_code | input | 10 | Amplifier gain code |
| tgt_wr_en | input | 1 | Target register write strobe |
| tgt_wr_data | input | 10 | New black target code |
| coarse_code | output | 8 | Coarse correction DAC code, unsigned |
| fine_code | output | 9 | Fine correction DAC code, two's complement |
| settled | output | 1 | Loop within ±1 LSB with no coarse step |

## Verification
The bench closes the loop through a plant model of the sensor offset, with both DAC weights, and compares every line against a model written from the requirements. The corner cases are aimed at specific mistakes. A short window is run: a design that updates on it would shift the codes. Extra bright samples are sent after the sixteenth, and valid gaps are inserted: a design that counts them would average the wrong value. A gain change is made mid-window on a line where the fine residue sits just past +255: a design that reads the live gain would preset the fine code one LSB off. Finally the coarse code is driven into both of its limits: a design that wraps would jump from 0 to 255 or from 255 to 0.

// File: rtl/bl_cal_pkg.sv
package bl_cal_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_dir_e;

  localparam int unsigned BAND_EDGE_3 = 128;
  localparam int unsigned BAND_EDGE_2 = 192;
  localparam int unsigned BAND_EDGE_1 = 256;
endpackage

// File: rtl/bl_window_avg.sv
module bl_window_avg #(
  parameter int ADC_W   = 10,
  parameter int AVG_LOG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clamp_n,
  input  logic             s_valid,
  input  logic [ADC_W-1:0] s_data,
  output logic             win_start,
  output logic             win_end,
  output logic             win_full,
  output logic [ADC_W-1:0] avg
);
  localparam int N_SAMP = 1 << AVG_LOG;
  localparam int ACC_W  = ADC_W + AVG_LOG;
  localparam int CNT_W  = AVG_LOG + 1;

  logic             clamp_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] acc_q;
  logic             take;

  assign win_start = clamp_q & ~clamp_n;
  assign win_end   = ~clamp_q & clamp_n;
  assign win_full  = (cnt_q == CNT_W'(N_SAMP));
  assign take      = ~clamp_n & s_valid & (win_start | (cnt_q < CNT_W'(N_SAMP)));
  assign avg       = acc_q[ACC_W-1:AVG_LOG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clamp_q <= 1'b1;
      cnt_q   <= '0;
      acc_q   <= '0;
    end else begin
      clamp_q <= clamp_n;
      if (win_start) begin
        cnt_q <= take ? CNT_W'(1) : '0;
        acc_q <= take ? ACC_W'(s_data) : '0;
      end else if (take) begin
        cnt_q <= cnt_q + CNT_W'(1);
        acc_q <= acc_q + ACC_W'(s_data);
      end
    end
  end
endmodule

// File: rtl/bl_step_weight.sv
module bl_step_weight #(
  parameter int GAIN_W    = 10,
  parameter int GAIN_FRAC = 7,
  parameter int W_W       = GAIN_W + 3 - GAIN_FRAC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [GAIN_W-1:0] gain_code,
  output logic [W_W-1:0]    weight
);
  import bl_cal_pkg::*;
  localparam int PROD_W = GAIN_W + 3;

  logic [GAIN_W-1:0] gain_q;
  logic [2:0]        band_n;
  logic [PROD_W-1:0] prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gain_q <= '0;
    else if (load) gain_q <= gain_code;
  end

  always_comb begin
    if (32'(gain_q) < BAND_EDGE_3)      band_n = 3'd4;
    else if (32'(gain_q) < BAND_EDGE_2) band_n = 3'd3;
    else if (32'(gain_q) < BAND_EDGE_1) band_n = 3'd2;
    else                                band_n = 3'd1;
  end

  assign prod   = PROD_W'(band_n) * (PROD_W'(gain_q) + PROD_W'(1 << GAIN_FRAC));
  assign weight = prod[PROD_W-1:GAIN_FRAC];
endmodule

// File: rtl/bl_offset_update.sv
module bl_offset_update #(
  parameter int ADC_W  = 10,
  parameter int CDAC_W = 8,
  parameter int FDAC_W = 9,
  parameter int W_W    = 6
) (
  input  logic [ADC_W-1:0]  avg,
  input  logic [ADC_W-1:0]  target,
  input  logic [CDAC_W-1:0] coarse_cur,
  input  logic [FDAC_W-1:0] fine_cur,
  input  logic [W_W-1:0]    weight,
  output logic [CDAC_W-1:0] coarse_nxt,
  output logic [FDAC_W-1:0] fine_nxt,
  output logic              settled_nxt
);
  import bl_cal_pkg::*;
  localparam int R_W = ADC_W + 3;
  localparam logic signed [R_W-1:0] FMAX = R_W'((1 << (FDAC_W - 1)) - 1);
  localparam logic [CDAC_W-1:0] C_TOP = '1;

  logic signed [R_W-1:0] err, freq, fine_s, w_s;
  step_dir_e             dir;

  function automatic logic [FDAC_W-1:0] sat_fine(input logic signed [R_W-1:0] v);
    if (v > FMAX)       return FMAX[FDAC_W-1:0];
    else if (v < -FMAX) return (-FMAX);
    else                return v[FDAC_W-1:0];
  endfunction

  assign fine_s = {{(R_W-FDAC_W){fine_cur[FDAC_W-1]}}, fine_cur};
  assign w_s    = {{(R_W-W_W){1'b0}}, weight};
  assign err    = $signed({3'b000, avg}) - $signed({3'b000, target});
  assign freq   = fine_s - err;

  always_comb begin
    if (freq > FMAX && coarse_cur != C_TOP)      dir = STEP_UP;
    else if (freq < -FMAX && coarse_cur != '0)   dir = STEP_DOWN;
    else                                         dir = STEP_NONE;
  end

  always_comb begin
    unique case (dir)
      STEP_UP: begin
        coarse_nxt = coarse_cur + CDAC_W'(1);
        fine_nxt   = sat_fine(freq - w_s);
      end
      STEP_DOWN: begin
        coarse_nxt = coarse_cur - CDAC_W'(1);
        fine_nxt   = sat_fine(freq + w_s);
      end
      default: begin
        coarse_nxt = coarse_cur;
        fine_nxt   = sat_fine(freq);
      end
    endcase
  end

  assign settled_nxt = (dir == STEP_NONE) && (err >= -R_W'(1)) && (err <= R_W'(1));
endmodule

// File: rtl/bl_offset_cal.sv
module bl_offset_cal #(
  parameter int ADC_W     = 10,
  parameter int AVG_LOG   = 4,
  parameter int GAIN_W    = 10,
  parameter int GAIN_FRAC = 7,
  parameter int CDAC_W    = 8,
  parameter int FDAC_W    = 9,
  parameter int TGT_RESET = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clamp_n,
  input  logic              adc_valid,
  output logic              adc_ready,
  input  logic [ADC_W-1:0]  adc_data,
  input  logic [GAIN_W-1:0] gain_code,
  input  logic              tgt_wr_en,
  input  logic [ADC_W-1:0]  tgt_wr_data,
  output logic [CDAC_W-1:0] coarse_code,
  output logic [FDAC_W-1:0] fine_code,
  output logic              settled
);
  localparam int W_W = GAIN_W + 3 - GAIN_FRAC;
  localparam logic [CDAC_W-1:0] C_MID = CDAC_W'(1 << (CDAC_W - 1));

  logic              win_start, win_end, win_full, cal_update;
  logic [ADC_W-1:0]  avg, target_q;
  logic [W_W-1:0]    weight;
  logic [CDAC_W-1:0] coarse_nxt;
  logic [FDAC_W-1:0] fine_nxt;
  logic              settled_nxt;

  assign adc_ready  = 1'b1;
  assign cal_update = win_end & win_full;

  bl_window_avg #(.ADC_W(ADC_W), .AVG_LOG(AVG_LOG)) u_avg (
    .clk(clk), .rst_n(rst_n), .clamp_n(clamp_n), .s_valid(adc_valid),
    .s_data(adc_data), .win_start(win_start), .win_end(win_end),
    .win_full(win_full), .avg(avg)
  );

  bl_step_weight #(.GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .W_W(W_W)) u_wt (
    .clk(clk), .rst_n(rst_n), .load(win_start), .gain_code(gain_code),
    .weight(weight)
  );

  bl_offset_update #(.ADC_W(ADC_W), .CDAC_W(CDAC_W), .FDAC_W(FDAC_W), .W_W(W_W)) u_upd (
    .avg(avg), .target(target_q), .coarse_cur(coarse_code), .fine_cur(fine_code),
    .weight(weight), .coarse_nxt(coarse_nxt), .fine_nxt(fine_nxt),
    .settled_nxt(settled_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         target_q <= ADC_W'(TGT_RESET);
    else if (tgt_wr_en) target_q <= tgt_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_code <= C_MID;
      fine_code   <= '0;
      settled     <= 1'b0;
    end else if (cal_update) begin
      coarse_code <= coarse_nxt;
      fine_code   <= fine_nxt;
      settled     <= settled_nxt;
    end
  end
endmodule

// File: rtl/bl_offset_cal_chk.sv
module bl_offset_cal_chk #(
  parameter int CDAC_W = 8,
  parameter int FDAC_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_update,
  input logic              adc_ready,
  input logic [CDAC_W-1:0] coarse_code,
  input logic [FDAC_W-1:0] fine_code,
  input logic              settled
);
  localparam int FMAX = (1 << (FDAC_W - 1)) - 1;

  // R4
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_update |=> ($stable(coarse_code) && $stable(fine_code) && $stable(settled)));

  // R6
  coarse_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_update |=> ((int'(coarse_code) - int'($past(coarse_code)) >= -1) &&
                    (int'(coarse_code) - int'($past(coarse_code)) <= 1)));

  // R9
  fine_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $signed(fine_code) >= -FMAX);

  // R10
  settled_coarse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> $stable(coarse_code));

  // R13
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ready);
endmodule

bind bl_offset_cal bl_offset_cal_chk #(.CDAC_W(CDAC_W), .FDAC_W(FDAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_update(cal_update), .adc_ready(adc_ready),
  .coarse_code(coarse_code), .fine_code(fine_code), .settled(settled)
);

// File: tb/bl_offset_cal_tb.sv
module bl_offset_cal_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  localparam int V_RAW  [NVEC] = '{300, 700, 10, 500, 250};
  localparam int V_TGT  [NVEC] = '{-1, 64, 600, 64, 200};
  localparam int V_GAIN [NVEC] = '{0, 100, 300, 150, 200};
  localparam int V_LINES[NVEC] = '{20, 250, 250, 250, 250};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clamp_n = 1'b1, adc_valid = 1'b0, tgt_wr_en = 1'b0;
  logic [9:0] adc_data = '0, gain_code = '0, tgt_wr_data = '0;
  logic       adc_ready, settled;
  logic [7:0] coarse_code;
  logic [8:0] fine_code;

  int n_chk = 0, n_fail = 0;
  int m_coarse = 128, m_fine = 0, m_settled = 0, m_target = 64;
  int p_raw = 0, force_val = -1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bl_offset_cal u_dut (
    .clk(clk), .rst_n(rst_n), .clamp_n(clamp_n), .adc_valid(adc_valid),
    .adc_ready(adc_ready), .adc_data(adc_data), .gain_code(gain_code),
    .tgt_wr_en(tgt_wr_en), .tgt_wr_data(tgt_wr_data), .coarse_code(coarse_code),
    .fine_code(fine_code), .settled(settled)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wfun(input int g);
    int n;
    n = (g < 128) ? 4 : (g < 192) ? 3 : (g < 256) ? 2 : 1;
    return (n * (128 + g)) / 128;
  endfunction

  function automatic int satf(input int v);
    return (v > 255) ? 255 : (v < -255) ? -255 : v;
  endfunction

  function automatic int sample_at(input int i);
    int v;
    if (force_val >= 0) return force_val;
    if (i >= 16) return 1023;
    v = p_raw + (int'(coarse_code) - 128) * wfun(int'(gain_code)) + int'($signed(fine_code));
    v = v + ((i % 2) ? 3 : -3);
    return (v < 0) ? 0 : (v > 1023) ? 1023 : v;
  endfunction

  task automatic model_update(input int avg, input int g);
    int e, f, nf, step;
    e = avg - m_target;
    f = m_fine - e;
    step = 0;
    if (f > 255 && m_coarse < 255) begin m_coarse++; nf = f - wfun(g); step = 1; end
    else if (f < -255 && m_coarse > 0) begin m_coarse--; nf = f + wfun(g); step = 1; end
    else nf = f;
    m_fine = satf(nf);
    m_settled = (e >= -1 && e <= 1 && step == 0) ? 1 : 0;
  endtask

  task automatic write_target(input int v);
    @(negedge clk); tgt_wr_en = 1'b1; tgt_wr_data = 10'(v);
    @(negedge clk); tgt_wr_en = 1'b0;
    m_target = v;
  endtask

  task automatic run_line(input int nvalid, input int nextra, input bit gaps,
                          input int gain_mid, input string tag);
    int sum = 0, cnt = 0, g_lat, s;
    @(negedge clk);
    g_lat = int'(gain_code);
    clamp_n = 1'b0;
    for (int i = 0; i < nvalid + nextra; i++) begin
      if (gaps && (i % 3 == 1)) begin
        adc_valid = 1'b0; adc_data = 10'd1023;
        @(negedge clk);
      end
      s = sample_at(i);
      adc_valid = 1'b1; adc_data = 10'(s);
      if (cnt < 16) begin sum += s; cnt++; end
      if (i == 2 && gain_mid >= 0) gain_code = 10'(gain_mid);
      @(negedge clk);
    end
    // R4: nothing has moved inside the window
    chk(int'(coarse_code) == m_coarse, {"R4 coarse hold ", tag}, int'(coarse_code), m_coarse);
    clamp_n = 1'b1; adc_valid = 1'b0;
    @(negedge clk);
    if (cnt >= 16 && nvalid >= 16) model_update(sum >> 4, g_lat);
    chk(int'(coarse_code) == m_coarse, {"R5/R6/R8 coarse ", tag}, int'(coarse_code), m_coarse);
    chk(int'($signed(fine_code)) == m_fine, {"R5/R6/R9 fine ", tag}, int'($signed(fine_code)), m_fine);
    chk(int'(settled) == m_settled, {"R10 settled ", tag}, int'(settled), m_settled);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R13 ready
    chk(coarse_code == 8'd128, "R1 coarse reset", int'(coarse_code), 128);
    chk(fine_code == 9'd0, "R1 fine reset", int'(fine_code), 0);
    chk(settled == 1'b0, "R1 settled reset", int'(settled), 0);
    chk(adc_ready == 1'b1, "R13 ready", int'(adc_ready), 1);

    // Table walk: vector 0 relies on the reset target (R1), others load it (R11), gain bands (R7)
    for (int v = 0; v < NVEC; v++) begin
      if (V_TGT[v] >= 0) write_target(V_TGT[v]);
      gain_code = 10'(V_GAIN[v]);
      p_raw = V_RAW[v];
      for (int l = 0; l < V_LINES[v]; l++) run_line(16, 0, 1'b0, -1, "R11 R7 vector");
      chk(settled == 1'b1, "R10 converged", int'(settled), 1);
    end

    // R3 short window
    run_line(10, 0, 1'b0, -1, "R3 short window");
    // R2 valid gaps and samples past the sixteenth
    p_raw = p_raw + 40;
    run_line(16, 5, 1'b1, -1, "R2 gaps extras");
    run_line(16, 0, 1'b0, -1, "R2 follow");

    // R12 / R7: residue just past +255, gain moves mid-window
    write_target(512);
    gain_code = 10'd0;
    force_val = 512 + m_fine - 257;
    run_line(16, 0, 1'b0, 300, "R12 gain latch");
    chk(m_fine == 253, "R12 preset fine", m_fine, 253);

    // R8 coarse lower limit
    write_target(0);
    force_val = 1023;
    for (int l = 0; l < 140; l++) run_line(16, 0, 1'b0, -1, "R8 floor");
    chk(coarse_code == 8'd0, "R8 floor held", int'(coarse_code), 0);
    // R8 coarse upper limit
    write_target(1023);
    force_val = 0;
    for (int l = 0; l < 270; l++) run_line(16, 0, 1'b0, -1, "R8 ceiling");
    chk(coarse_code == 8'd255, "R8 ceiling held", int'(coarse_code), 255);
    chk(adc_ready == 1'b1, "R13 ready end", int'(adc_ready), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule